// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. Software starts a conversion by writing the start bit to 1, together with a channel, a resolution (8 or 10 bits), a mode (one-shot or repeat), a sample-and-hold enable and a conversion-clock divider. The block puts a trial code on `trial_o` for an external DAC and comparator. It takes one comparator decision per conversion-clock tick, working from the most significant bit down, and it writes the finished code to a result register.

Every conversion lasts a fixed number of conversion-clock ticks. That number depends on the resolution and on whether sample-and-hold is used. The ticks that the bit decisions do not need come first, as a sampling phase. A done flag is raised for one base-clock cycle each time a result is written. In one-shot mode the start bit clears itself at that moment. In repeat mode conversions run back to back at 8-bit resolution until software clears the bit. Clearing the bit in the middle of a conversion abandons it.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `start_o`, `busy_o` and `done_o` are 0, and `result_o` and `trial_o` are all zeros.
- R2: With `cmp_i` = 1 whenever the trial code is at or below the sampled input, the result equals the input exactly. The trial bits are resolved MSB first, so the first trial code is 512 in 10-bit mode and 128 in 8-bit mode.
- R3: An 8-bit result is right-aligned in `result_o`, and bits 9:8 are zero.
- R4: A conversion lasts T conversion-clock ticks, with T = 49 (8-bit, no S&H), 59 (10-bit, no S&H), 28 (8-bit, S&H) or 33 (10-bit, S&H). `done_o` rises T*D base cycles after the clock edge that accepted the start write.
- R5: `div_i` selects the divisor D: 0 gives D = 1, 1 gives D = 2, and 2 or 3 gives D = 4.
- R6: For the first (T-N)*D base cycles of a conversion (N = resolution bits), `trial_o` stays 0. In the cycle after that, it shows the first trial code.
- R7: `done_o` is high for exactly one base-clock cycle per completed conversion.
- R8: In one-shot mode, `start_o` falls in the same cycle that `done_o` rises.
- R9: In repeat mode (`repeat_i` = 1), resolution is forced to 8 bits whatever `res10_i` is. `start_o` stays 1, and results keep arriving every 49*D (or 28*D) base cycles until software writes 0.
- R10: A start write with `chan_i` of 12 to 15 is ignored: `start_o` and `busy_o` stay 0 and no result appears. During a conversion, `chan_o` shows the channel that was latched at start.
- R11: Writing the start bit to 0 during a conversion stops it: `busy_o` and `start_o` fall, no done is raised, and `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | Write strobe for the start bit |
| start_wdata_i | input | 1 | Value written to the start bit |
| chan_i | input | 4 | Channel select, valid codes 0 to 11 |
| res10_i | input | 1 | 1 selects 10-bit resolution, 0 selects 8-bit |
| repeat_i | input | 1 | 1 selects repeat mode |
| sh_en_i | input | 1 | Sample-and-hold enable |
| div_i | input | 2 | Conversion-clock divider select |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| trial_o | output | 10 | Trial code to the DAC |
| chan_o | output | 4 | Latched channel for the input multiplexer |
| busy_o | output | 1 | Conversion in progress |
| start_o | output | 1 | Current state of the start bit |
| result_o | output | 10 | Result register |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its default parameters: 10-bit full scale, 8-bit low resolution and 12 channels. These are small enough to cover every input code at both resolutions: all 256 codes at 8 bits and all 1024 codes at 10 bits, with the divider at 1. A second sweep walks all four divider codes against every pairing of resolution and S&H, and checks the exact conversion length, where the sampling phase ends and the first trial code. Repeat timing, the forced 8-bit mode, aborts and all four invalid channel codes are each run as directed cases.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int DIV_W = 3;

  typedef logic [1:0] div_sel_t;

  function automatic logic [DIV_W-1:0] div_limit(input div_sel_t sel);
    case (sel)
      2'd0:    return DIV_W'(1);
      2'd1:    return DIV_W'(2);
      default: return DIV_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div
  import sar_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  div_sel_t sel_i,
  output logic     tick_o
);
  logic [DIV_W-1:0] dcnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = div_limit(sel_i);
  assign tick_o = run_i && (dcnt_q == lim - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dcnt_q <= '0;
    else if (!run_i)  dcnt_q <= '0;
    else if (tick_o)  dcnt_q <= '0;
    else              dcnt_q <= dcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] nbits_i,
  output logic             bit_phase_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] samp;

  // sampling ticks = total ticks minus decision ticks
  assign samp        = len_i - nbits_i;
  assign bit_phase_o = run_i && (cnt_q >= samp);
  assign idx_o       = nbits_i - CNT_W'(1) - (cnt_q - samp);
  assign last_o      = (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int ADC_W = 10,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             wrap_i,
  input  logic             bit_phase_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [ADC_W-1:0] trial_o,
  output logic [ADC_W-1:0] acc_nxt_o
);
  logic [ADC_W-1:0] acc_q;

  for (genvar b = 0; b < ADC_W; b++) begin : g_bit
    logic sel;
    assign sel          = bit_phase_i && (idx_i == CNT_W'(b));
    assign trial_o[b]   = acc_q[b] | sel;
    assign acc_nxt_o[b] = sel ? cmp_i : acc_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (wrap_i)  acc_q <= '0;
    else if (step_i)  acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int RES_LO    = 8,
  parameter int NCH       = 12,
  parameter int CH_W      = 4,
  parameter int LEN_LO    = 49,
  parameter int LEN_HI    = 59,
  parameter int LEN_LO_SH = 28,
  parameter int LEN_HI_SH = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_wr_i,
  input  logic             start_wdata_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             res10_i,
  input  logic             repeat_i,
  input  logic             sh_en_i,
  input  logic [1:0]       div_i,
  input  logic             cmp_i,
  output logic [ADC_W-1:0] trial_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             busy_o,
  output logic             start_o,
  output logic [ADC_W-1:0] result_o,
  output logic             done_o
);
  localparam int LEN_MAX = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic             start_q, busy_q, done_q, res10_q, sh_q, rep_q;
  logic [CH_W-1:0]  chan_q;
  div_sel_t         div_q;
  logic [ADC_W-1:0] result_q;

  logic             tick, bit_phase, last;
  logic [CNT_W-1:0] idx, len, nbits;
  logic [ADC_W-1:0] trial, acc_nxt;
  logic             wr_go, wr_stop, fin;

  assign wr_go   = start_wr_i && start_wdata_i && !busy_q && (chan_i < CH_W'(NCH));
  assign wr_stop = start_wr_i && !start_wdata_i;
  assign fin     = busy_q && tick && last;

  assign nbits = res10_q ? CNT_W'(ADC_W) : CNT_W'(RES_LO);
  always_comb begin
    case ({res10_q, sh_q})
      2'b00:   len = CNT_W'(LEN_LO);
      2'b10:   len = CNT_W'(LEN_HI);
      2'b01:   len = CNT_W'(LEN_LO_SH);
      default: len = CNT_W'(LEN_HI_SH);
    endcase
  end

  sar_clk_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .sel_i  (div_q),
    .tick_o (tick)
  );

  sar_step_ctrl #(.CNT_W(CNT_W)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_q),
    .tick_i      (tick),
    .len_i       (len),
    .nbits_i     (nbits),
    .bit_phase_o (bit_phase),
    .idx_o       (idx),
    .last_o      (last)
  );

  sar_approx #(.ADC_W(ADC_W), .CNT_W(CNT_W)) u_approx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (!busy_q),
    .step_i      (tick && bit_phase),
    .wrap_i      (fin),
    .bit_phase_i (bit_phase),
    .idx_i       (idx),
    .cmp_i       (cmp_i),
    .trial_o     (trial),
    .acc_nxt_o   (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      res10_q  <= 1'b0;
      sh_q     <= 1'b0;
      rep_q    <= 1'b0;
      chan_q   <= '0;
      div_q    <= '0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_stop) begin
        start_q <= 1'b0;
        busy_q  <= 1'b0;
      end else if (wr_go) begin
        start_q <= 1'b1;
        busy_q  <= 1'b1;
        chan_q  <= chan_i;
        res10_q <= res10_i && !repeat_i;  // repeat runs at low resolution only
        sh_q    <= sh_en_i;
        rep_q   <= repeat_i;
        div_q   <= div_i;
      end else if (fin) begin
        result_q <= acc_nxt;
        done_q   <= 1'b1;
        if (!rep_q) begin
          start_q <= 1'b0;
          busy_q  <= 1'b0;
        end
      end
    end
  end

  assign trial_o  = busy_q ? trial : '0;
  assign chan_o   = chan_q;
  assign busy_o   = busy_q;
  assign start_o  = start_q;
  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int ADC_W  = 10,
  parameter int RES_LO = 8,
  parameter int NCH    = 12,
  parameter int CH_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [ADC_W-1:0] trial_o,
  input logic [ADC_W-1:0] result_o,
  input logic [CH_W-1:0]  chan_o,
  input logic             res10_q,
  input logic             rep_q
);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !res10_q) |-> (result_o[ADC_W-1:RES_LO] == '0));

  p_oneshot_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rep_q) |-> (!start_o && !busy_o));

  p_repeat_low_res_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rep_q) |-> (!res10_q && start_o));

  p_idle_trial_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (trial_o == '0));

  p_valid_chan_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (chan_o < CH_W'(NCH)));

  p_abort_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !done_o) |-> $stable(result_o));
endmodule

bind sar_seq_top sar_seq_chk #(
  .ADC_W (ADC_W),
  .RES_LO(RES_LO),
  .NCH   (NCH),
  .CH_W  (CH_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_o (start_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .trial_o (trial_o),
  .result_o(result_o),
  .chan_o  (chan_o),
  .res10_q (res10_q),
  .rep_q   (rep_q)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_wr_i, start_wdata_i, res10_i, repeat_i, sh_en_i, cmp_i;
  logic [3:0] chan_i, chan_o;
  logic [1:0] div_i;
  logic [9:0] trial_o, result_o;
  logic       busy_o, start_o, done_o;
  logic [10:0] target;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  // comparator model: keep the trial bit while the trial is not above the input
  assign cmp_i = ({1'b0, trial_o} <= target);

  sar_seq_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_wr_i(start_wr_i), .start_wdata_i(start_wdata_i),
    .chan_i(chan_i), .res10_i(res10_i), .repeat_i(repeat_i), .sh_en_i(sh_en_i),
    .div_i(div_i), .cmp_i(cmp_i), .trial_o(trial_o), .chan_o(chan_o), .busy_o(busy_o),
    .start_o(start_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit r10, input bit sh);
    if (sh) return r10 ? 33 : 28;
    return r10 ? 59 : 49;
  endfunction

  function automatic int exp_div(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
  endfunction

  task automatic write_start(input bit val);
    @(negedge clk_i);
    start_wr_i = 1'b1;
    start_wdata_i = val;
    @(posedge clk_i);
    #1 start_wr_i = 1'b0;
  endtask

  // one-shot conversion; full enables the timing checks
  task automatic do_conv(input logic [3:0] ch, input bit r10, input bit sh,
                         input int dv, input int tgt, input bit full);
    int n = 0;
    int first = -1;
    int ftrial = 0;
    int t = exp_len(r10, sh);
    int d = exp_div(dv);
    int nb = r10 ? 10 : 8;
    target = 11'(tgt);
    @(negedge clk_i);
    chan_i = ch; res10_i = r10; sh_en_i = sh; repeat_i = 1'b0; div_i = 2'(dv);
    write_start(1'b1);
    if (full) chk(chan_o == ch, "R10 chan_o latched", int'(chan_o), int'(ch));
    while (!done_o && n < 2000) begin
      if (trial_o != 0 && first < 0) begin
        first = n;
        ftrial = int'(trial_o);
      end
      @(posedge clk_i); #1; n++;
    end
    chk(result_o == 10'(tgt), "R2 result", int'(result_o), tgt);
    if (full) begin
      chk(n == t * d, "R4/R5 conversion length", n, t * d);
      chk(first == (t - nb) * d, "R6 sampling phase end", first, (t - nb) * d);
      chk(ftrial == (1 << (nb - 1)), "R2 MSB first trial", ftrial, 1 << (nb - 1));
      chk(!start_o && !busy_o, "R8 start bit self-clears", int'(start_o), 0);
      if (!r10) chk(result_o[9:8] == 2'b00, "R3 upper bits zero", int'(result_o[9:8]), 0);
      @(posedge clk_i); #1;
      chk(!done_o, "R7 done one cycle", int'(done_o), 0);
    end
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    int tprev;
    int n;
    rst_ni = 1'b0; start_wr_i = 1'b0; start_wdata_i = 1'b0; chan_i = '0;
    res10_i = 1'b0; repeat_i = 1'b0; sh_en_i = 1'b0; div_i = '0; target = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    chk(!start_o && !busy_o && !done_o, "R1 reset flags", int'({start_o, busy_o, done_o}), 0);
    chk(result_o == 0 && trial_o == 0, "R1 reset data", int'(result_o), 0);

    // exhaustive codes at both resolutions (R2, R3)
    for (int v = 0; v < 256; v++) do_conv(4'(v % 12), 1'b0, 1'b0, 0, v, v == 255);
    for (int v = 0; v < 1024; v++) do_conv(4'(v % 12), 1'b1, 1'b1, 0, v, v == 1023);

    // timing sweep: divider x resolution x S&H (R4, R5, R6)
    for (int dv = 0; dv < 4; dv++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 2; s++)
          do_conv(4'(11 - dv), r[0], s[0], dv, r ? 10'h2A5 : 8'h5A, 1'b1);

    // R11: abort keeps previous result
    do_conv(4'd3, 1'b1, 1'b0, 0, 300, 1'b0);
    target = 11'd777;
    @(negedge clk_i);
    res10_i = 1'b1; sh_en_i = 1'b0; div_i = 2'd0;
    write_start(1'b1);
    repeat (30) @(posedge clk_i);
    write_start(1'b0);
    chk(!busy_o && !start_o, "R11 abort stops", int'(busy_o), 0);
    seen = 0;
    repeat (100) begin @(posedge clk_i); #1; if (done_o) seen++; end
    chk(seen == 0, "R11 no done after abort", seen, 0);
    chk(result_o == 10'd300, "R11 result kept", int'(result_o), 300);

    // R10: invalid channel codes ignored
    for (int c = 12; c < 16; c++) begin
      @(negedge clk_i);
      chan_i = 4'(c);
      write_start(1'b1);
      chk(!start_o && !busy_o, "R10 invalid channel ignored", int'(start_o), 0);
      seen = 0;
      repeat (70) begin @(posedge clk_i); #1; if (done_o) seen++; end
      chk(seen == 0 && result_o == 10'd300, "R10 no result for invalid channel", seen, 0);
    end

    // R9: repeat forced to 8 bits, back to back
    for (int s = 0; s < 2; s++) begin
      target = 11'd200;
      @(negedge clk_i);
      chan_i = 4'd5; res10_i = 1'b1; repeat_i = 1'b1; sh_en_i = s[0]; div_i = 2'd1;
      write_start(1'b1);
      n = 0; seen = 0; tprev = 0;
      while (seen < 3 && n < 1000) begin
        @(posedge clk_i); #1; n++;
        if (done_o) begin
          chk(n - tprev == exp_len(1'b0, s[0]) * 2, "R9 repeat interval", n - tprev,
              exp_len(1'b0, s[0]) * 2);
          chk(result_o == 10'd200 && start_o, "R9 repeat result, start held",
              int'(result_o), 200);
          tprev = n;
          seen++;
        end
      end
      chk(seen == 3, "R9 repeat count", seen, 3);
      write_start(1'b0);
      chk(!start_o && !busy_o, "R9 repeat stopped by software", int'(start_o), 0);
      seen = 0;
      repeat (120) begin @(posedge clk_i); #1; if (done_o) seen++; end
      chk(seen == 0, "R9 no done after stop", seen, 0);
      repeat_i = 1'b0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule